// File: doc/BRIEF.md
# Dual-Rate LED Dimmer Bank

The block drives sixteen active-low LED pins from a small register file. Each pin carries a two-bit mode: released (dark), driven low (lit), or slaved to one of two shared rate generators. A generator has a period register and a duty register. Any pin whose mode lets an outside source set its level can serve as a general-purpose pin: two read-only status registers return the synchronized level of every pin.

A host writes registers with an address, a data byte and a write strobe. It reads them through a combinational read-data port that shows the currently addressed register. A free-running base tick divides the clock by `TICK_DIV`. Each generator steps an 8-bit phase once every (period register + 1) base ticks. Each generator is a two-state machine. `GEN_DARK` goes to `GEN_LIT` when the phase is below the duty value. `GEN_LIT` goes back to `GEN_DARK` when the phase reaches the duty value, or when the duty value is lowered below the phase. Otherwise each state holds.

Top module: `led_dimmer_bank`

## Requirements
- R1: While `rst_n` is low and right after it rises, every `led_out_n` bit is 1, both period registers read 8'h00, both duty registers read 8'h80 and all four mode registers read 8'h00.
- R2: Address map: 2 = period of rate 0, 3 = duty of rate 0, 4 = period of rate 1, 5 = duty of rate 1, 6..9 = mode registers. A write takes effect at the clock edge that samples `reg_we`. A read in the cycle of the write still returns the old value. Addresses 10..15 read 8'h00 and ignore writes.
- R3: Mode 2'b00 releases the pin: `led_out_n` is 1 from the clock edge after the mode is in place.
- R4: Mode 2'b01 drives the pin: `led_out_n` is 0 from the clock edge after the mode is in place.
- R5: Mode 2'b10 makes the pin low exactly while rate generator 0 is lit. Mode 2'b11 does the same with generator 1.
- R6: A generator's period is 256*(P+1)*TICK_DIV clock cycles, where P is its period register. In each period it is lit for D*(P+1)*TICK_DIV cycles, where D is its duty register. D = 0 never lights the generator, and D = 255 leaves it dark for only one phase step.
- R7: Mode register at address 6+k holds the modes of LEDs 4k..4k+3. LED j uses bits [2*(j mod 4)+1 : 2*(j mod 4)].
- R8: Address 0 returns the levels of pins 0..7, with pin 0 in bit 0. Address 1 returns pins 8..15, with pin 8 in bit 0. Both are sampled through a two-flop synchronizer, and writes to these addresses change nothing.
- R9: A released pin reports the level an outside source puts on it. A pin in mode 2'b01 reports 0.
- R10: Writes presented while `rst_n` is low are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | AW (4) | Register address |
| reg_wdata | input | DW (8) | Write data |
| reg_rdata | output | DW (8) | Read data of the addressed register |
| pin_in | input | NUM_LEDS (16) | Sensed level of each pin |
| led_out_n | output | NUM_LEDS (16) | Pin drive, 0 = pulled low (lit), 1 = released |

## Verification
Two functions can fall in the same cycle: a host write and a host read of the same register. The bench raises the strobe on the duty register while that address is also selected for reading. It samples read data before the edge and expects the old value, then samples after the edge and expects the new one. The generators keep running during such writes, so duty changes are judged only after one full period has passed. The check counts lit cycles over an exact period window, where the count is fixed whatever the phase.

// File: rtl/ldb_pkg.sv
package ldb_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_ON    = 2'b01,
        MODE_RATE0 = 2'b10,
        MODE_RATE1 = 2'b11
    } led_mode_e;

    typedef enum logic {
        GEN_DARK = 1'b0,
        GEN_LIT  = 1'b1
    } gen_state_e;

    localparam int unsigned NUM_GENS = 2;
    localparam int unsigned RATE_REGS_PER_GEN = 2;
endpackage

// File: rtl/ldb_pin_sync.sv
module ldb_pin_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/ldb_rate_gen.sv
module ldb_rate_gen
    import ldb_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] period_cfg,
    input  logic [DW-1:0] duty_cfg,
    output logic          lit
);
    logic [DW-1:0] div_q;
    logic [DW-1:0] phase_q;
    gen_state_e    state_q;
    gen_state_e    state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= '0;
            phase_q <= '0;
        end else if (tick) begin
            if (div_q >= period_cfg) begin
                div_q   <= '0;
                phase_q <= phase_q + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_DARK: if (phase_q < duty_cfg)   state_d = GEN_LIT;
            GEN_LIT:  if (!(phase_q < duty_cfg)) state_d = GEN_DARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_DARK;
        else        state_q <= state_d;
    end

    assign lit = (state_q == GEN_LIT);
endmodule

// File: rtl/ldb_regfile.sv
module ldb_regfile
    import ldb_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 16,
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [AW-1:0]                addr,
    input  logic [DW-1:0]                wdata,
    output logic [DW-1:0]                rdata,
    input  logic [NUM_LEDS-1:0]          pin_level,
    output logic [NUM_GENS-1:0][DW-1:0]  period_cfg,
    output logic [NUM_GENS-1:0][DW-1:0]  duty_cfg,
    output logic [2*NUM_LEDS-1:0]        mode_flat
);
    localparam int unsigned STAT_REGS = NUM_LEDS / DW;
    localparam int unsigned RATE_REGS = NUM_GENS * RATE_REGS_PER_GEN;
    localparam int unsigned SEL_REGS  = (2 * NUM_LEDS) / DW;
    localparam int unsigned RATE_BASE = STAT_REGS;
    localparam int unsigned SEL_BASE  = RATE_BASE + RATE_REGS;
    localparam logic [DW-1:0] DUTY_HALF = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] rate_q [RATE_REGS];
    logic [DW-1:0] sel_q  [SEL_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RATE_REGS; i++)
                rate_q[i] <= (i % 2 == 1) ? DUTY_HALF : '0;
            for (int i = 0; i < SEL_REGS; i++)
                sel_q[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < RATE_REGS; i++)
                if (addr == AW'(RATE_BASE + i)) rate_q[i] <= wdata;
            for (int i = 0; i < SEL_REGS; i++)
                if (addr == AW'(SEL_BASE + i)) sel_q[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < STAT_REGS; i++)
            if (addr == AW'(i)) rdata = pin_level[i*DW +: DW];
        for (int i = 0; i < RATE_REGS; i++)
            if (addr == AW'(RATE_BASE + i)) rdata = rate_q[i];
        for (int i = 0; i < SEL_REGS; i++)
            if (addr == AW'(SEL_BASE + i)) rdata = sel_q[i];
    end

    for (genvar g = 0; g < NUM_GENS; g++) begin : g_rate_out
        assign period_cfg[g] = rate_q[RATE_REGS_PER_GEN*g];
        assign duty_cfg[g]   = rate_q[RATE_REGS_PER_GEN*g + 1];
    end

    for (genvar k = 0; k < SEL_REGS; k++) begin : g_sel_out
        assign mode_flat[k*DW +: DW] = sel_q[k];
    end
endmodule

// File: rtl/led_dimmer_bank.sv
module led_dimmer_bank
    import ldb_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 16,
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 4,
    parameter int unsigned TICK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [NUM_LEDS-1:0] pin_in,
    output logic [NUM_LEDS-1:0] led_out_n
);
    localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [TW-1:0]                tick_cnt_q;
    logic                         base_tick;
    logic [NUM_LEDS-1:0]          pin_sync;
    logic [NUM_GENS-1:0][DW-1:0]  period_cfg;
    logic [NUM_GENS-1:0][DW-1:0]  duty_cfg;
    logic [2*NUM_LEDS-1:0]        mode_flat;
    logic [NUM_GENS-1:0]          gen_lit;
    logic [NUM_LEDS-1:0]          out_d;

    assign base_tick = (tick_cnt_q == TW'(TICK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tick_cnt_q <= '0;
        else if (base_tick) tick_cnt_q <= '0;
        else                tick_cnt_q <= tick_cnt_q + 1'b1;
    end

    ldb_pin_sync #(.W(NUM_LEDS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    ldb_regfile #(.NUM_LEDS(NUM_LEDS), .DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .pin_level  (pin_sync),
        .period_cfg (period_cfg),
        .duty_cfg   (duty_cfg),
        .mode_flat  (mode_flat)
    );

    for (genvar g = 0; g < NUM_GENS; g++) begin : g_gen
        ldb_rate_gen #(.DW(DW)) u_gen (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (base_tick),
            .period_cfg (period_cfg[g]),
            .duty_cfg   (duty_cfg[g]),
            .lit        (gen_lit[g])
        );
    end

    always_comb begin
        for (int j = 0; j < NUM_LEDS; j++) begin
            unique case (led_mode_e'(mode_flat[2*j +: 2]))
                MODE_OFF:   out_d[j] = 1'b1;
                MODE_ON:    out_d[j] = 1'b0;
                MODE_RATE0: out_d[j] = ~gen_lit[0];
                MODE_RATE1: out_d[j] = ~gen_lit[1];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) led_out_n <= '1;
        else        led_out_n <= out_d;
    end
endmodule

// File: rtl/ldb_checker.sv
module ldb_checker
    import ldb_pkg::*;
#(
    parameter int unsigned NUM_LEDS = 16,
    parameter int unsigned DW       = 8,
    parameter int unsigned AW       = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_we,
    input logic [AW-1:0]               reg_addr,
    input logic [DW-1:0]               reg_wdata,
    input logic [NUM_LEDS-1:0]         led_out_n,
    input logic [2*NUM_LEDS-1:0]       mode_flat,
    input logic [NUM_GENS-1:0][DW-1:0] duty_cfg,
    input logic [NUM_GENS-1:0]         gen_lit
);
    localparam logic [AW-1:0] DUTY0_ADDR = AW'(NUM_LEDS / DW + 1);

    AST_DUTY0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == DUTY0_ADDR) |=> (duty_cfg[0] == $past(reg_wdata))); // R2

    for (genvar g = 0; g < NUM_GENS; g++) begin : g_gen_chk
        AST_ZERO_DUTY_DARK: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_cfg[g] == '0) |=> !gen_lit[g]); // R6
    end

    for (genvar j = 0; j < NUM_LEDS; j++) begin : g_led_chk
        AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_flat[2*j +: 2]) == MODE_OFF) |-> led_out_n[j]); // R3
        AST_ON_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_flat[2*j +: 2]) == MODE_ON) |-> !led_out_n[j]); // R4
        AST_RATE0_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_flat[2*j +: 2]) == MODE_RATE0) |-> (led_out_n[j] == !$past(gen_lit[0]))); // R5
        AST_RATE1_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_flat[2*j +: 2]) == MODE_RATE1) |-> (led_out_n[j] == !$past(gen_lit[1]))); // R5
    end
endmodule

bind led_dimmer_bank ldb_checker #(.NUM_LEDS(NUM_LEDS), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .led_out_n (led_out_n),
    .mode_flat (mode_flat),
    .duty_cfg  (duty_cfg),
    .gen_lit   (gen_lit)
);

// File: tb/sim_led_dimmer_bank.sv
`timescale 1ns/1ps
module sim_led_dimmer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] ext_drive = 16'hFFFF;
    logic [15:0] pin_in;
    logic [15:0] led_out_n;
    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    assign pin_in = led_out_n & ext_drive;

    led_dimmer_bank u0 (
        .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .pin_in (pin_in), .led_out_n (led_out_n)
    );

    // {address, write data, expected read-back}
    localparam logic [19:0] VEC [12] = '{
        {4'd2,  8'h05, 8'h05},   // R2 period 0
        {4'd3,  8'h40, 8'h40},   // R2 duty 0
        {4'd4,  8'h01, 8'h01},   // R2 period 1
        {4'd5,  8'hC0, 8'hC0},   // R2 duty 1
        {4'd0,  8'h12, 8'hFF},   // R8 status low not writable
        {4'd1,  8'h34, 8'hFF},   // R8 status high not writable
        {4'd12, 8'hAB, 8'h00},   // R2 unmapped
        {4'd15, 8'h77, 8'h00},   // R2 unmapped
        {4'd6,  8'hE4, 8'hE4},   // R7 mode reg 0
        {4'd9,  8'h1B, 8'h1B},   // R7 mode reg 3
        {4'd6,  8'h00, 8'h00},
        {4'd9,  8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic count_low(input int idx, input int ncyc, output int cnt);
        cnt = 0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (!led_out_n[idx]) cnt++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int c;
        repeat (4) @(negedge clk);
        check("R1 outputs in reset", 32'(led_out_n), 32'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 outputs after reset", 32'(led_out_n), 32'hFFFF);
        rd(4'd2, d); check("R1 period0", 32'(d), 32'h00);
        rd(4'd3, d); check("R1 duty0", 32'(d), 32'h80);
        rd(4'd4, d); check("R1 period1", 32'(d), 32'h00);
        rd(4'd5, d); check("R1 duty1", 32'(d), 32'h80);
        rd(4'd7, d); check("R1 mode reg", 32'(d), 32'h00);

        for (int v = 0; v < 12; v++) begin
            wr(VEC[v][19:16], VEC[v][15:8]);
            repeat (3) @(negedge clk);
            rd(VEC[v][19:16], d);
            check($sformatf("R2 vector %0d", v), 32'(d), 32'(VEC[v][7:0]));
        end

        // R2: write and read of the same register in one cycle
        @(negedge clk);
        reg_addr = 4'd5; reg_wdata = 8'h33; reg_we = 1'b1;
        #1 check("R2 same-cycle old value", 32'(reg_rdata), 32'hC0);
        @(negedge clk);
        reg_we = 1'b0;
        #1 check("R2 same-cycle new value", 32'(reg_rdata), 32'h33);
        wr(4'd5, 8'hC0);

        // R7 R3 R4: LED5 and LED7 on via mode reg at address 7
        ext_drive = 16'hFFEF;
        wr(4'd7, 8'h44);
        repeat (4) @(negedge clk);
        check("R7 R3 R4 field layout", 32'(led_out_n), 32'hFF5F);
        rd(4'd0, d); check("R8 R9 status low", 32'(d), 32'h4F);
        rd(4'd1, d); check("R8 status high", 32'(d), 32'hFF);
        wr(4'd7, 8'h00);
        ext_drive = 16'hFFFF;

        // R5 R6: LED0 on rate 0, LED8 on rate 1
        wr(4'd2, 8'h00);
        wr(4'd6, 8'h02);
        wr(4'd8, 8'h03);
        repeat (2100) @(negedge clk);
        count_low(0, 1024, c);
        check("R5 R6 rate0 duty 0x40", 32'(c), 32'd256);
        count_low(8, 2048, c);
        check("R5 R6 rate1 period 1 duty 0xC0", 32'(c), 32'd1536);
        wr(4'd3, 8'h00);
        repeat (1100) @(negedge clk);
        count_low(0, 1024, c);
        check("R6 duty zero", 32'(c), 32'd0);
        wr(4'd3, 8'hFF);
        repeat (1100) @(negedge clk);
        count_low(0, 1024, c);
        check("R6 duty full", 32'(c), 32'd1020);
        wr(4'd6, 8'h00);
        wr(4'd8, 8'h00);
        repeat (3) @(negedge clk);
        check("R3 released again", 32'(led_out_n), 32'hFFFF);

        // R10: writes under reset are dropped
        @(negedge clk);
        rst_n = 1'b0;
        reg_addr = 4'd3; reg_wdata = 8'h99; reg_we = 1'b1;
        repeat (3) @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(4'd3, d); check("R10 write under reset", 32'(d), 32'h80);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule